// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps a 16-bit virtual address onto a 24-bit physical address. The virtual space is split into sixteen pages of 4 KiB each. The top four virtual bits select one of sixteen 16-bit page descriptors. A descriptor holds a mapping-enable flag, a write-protect flag, a cacheable flag and a 12-bit physical frame number. The frame number becomes the upper twelve physical bits, and the twelve offset bits pass through unchanged.

A CPU presents an address, a valid strobe and a write flag. One clock later the block returns the physical address, a cacheable indication and a one-cycle fault pulse. Faults are also recorded per page in two sticky bitmaps: one for accesses to unmapped pages and one for writes to protected pages. Software sets up the descriptors and reads the bitmaps through a 16-bit register port. Each bitmap clears itself when it is read.

Top module: `pgx_mmu`

## Requirements
- R1: After reset, pa_o, cache_o and fault_o are 0, every descriptor reads back as 0 (all pages disabled), and both fault bitmaps read as 0.
- R2: One cycle after a valid access, pa_o equals {descriptor[15:4], va[11:0]}, where the descriptor is the one selected by va[15:12].
- R3: A register write at byte offset 2*n (n = 0..15, offset bit 0 ignored) stores descriptor n. A read returns the stored value on cfg_rdata one cycle after the read strobe, and descriptor bit 3 always reads as 0.
- R4: A valid access, read or write, to a page whose descriptor bit 0 is 0 drives fault_o high in the next cycle and sets that page's bit in the page-fault bitmap (offset 0x20). The write-fault bitmap is left unchanged.
- R5: A valid write to an enabled page whose descriptor bit 1 is 1 drives fault_o and sets that page's bit in the write-fault bitmap (offset 0x22). A valid read of the same page does not fault.
- R6: After a valid access, cache_o equals descriptor bit 2 when the access does not fault, and is 0 when it faults.
- R7: Fault bitmap bits stay set through later non-faulting accesses, and bits from faults on different pages accumulate.
- R8: A register read of a fault bitmap returns its contents, and the bitmap is 0 afterwards.
- R9: If a fault occurs in the same cycle that its bitmap is read, the read returns the old contents and the bitmap afterwards holds only the new bit.
- R10: Register writes to offsets 0x20, 0x22 and anything above 0x22 change no state. Reads of offsets above 0x22 return 0.
- R11: fault_o is 0 in any cycle that does not directly follow a valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_valid | input | 1 | Translation request strobe |
| xl_write | input | 1 | Request is a write (1) or a read (0) |
| xl_va | input | 16 | Virtual address |
| pa_o | output | 24 | Registered physical address |
| cache_o | output | 1 | Registered cacheable indication |
| fault_o | output | 1 | One-cycle fault pulse |
| cfg_sel | input | 1 | Register port strobe |
| cfg_we | input | 1 | Register port write (1) or read (0) |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered register read data |

## Verification
Translation is driven with frame numbers whose fields differ bit by bit and with offsets at both ends of a page. A swapped or truncated field in pa_o therefore shows up directly. Accesses are run against disabled pages, enabled writable pages and enabled write-protected pages, with both read and write direction on each. This separates the page-fault path from the write-fault path, and shows that the cacheable flag is suppressed only on faulting accesses. The register port is tried with a reserved bit set in the write data, with writes to the read-only and unused offsets, and with a bitmap read in the same cycle as a new fault. These cases show masking, ignored writes and the clear-on-read ordering.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PAGE_BITS  = 4;
  localparam int OFF_BITS   = 12;
  localparam int FRAME_BITS = 12;
  localparam int DESC_W     = 16;
  localparam int CFG_AW     = 6;
  // descriptor field positions
  localparam int EN_BIT     = 0;
  localparam int WP_BIT     = 1;
  localparam int CA_BIT     = 2;
  localparam int RSV_BIT    = 3;
  localparam int FRAME_LSB  = 4;
endpackage

// File: rtl/pgx_desc_file.sv
module pgx_desc_file
  import pgx_pkg::*;
#(
  parameter int NPAGES = 16,
  parameter int PW     = 4,
  parameter int DW     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [PW-1:0]        lk_page,
  output logic [DW-1:0]        lk_desc,
  input  logic [PW-1:0]        rd_idx,
  output logic [DW-1:0]        rd_desc,
  output logic [NPAGES*DW-1:0] desc_flat
);
  localparam logic [DW-1:0] RSV_MASK = DW'(1) << RSV_BIT;

  logic [DW-1:0] mem [NPAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAGES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data & ~RSV_MASK;
    end
  end

  assign lk_desc = mem[lk_page];
  assign rd_desc = mem[rd_idx];

  for (genvar g = 0; g < NPAGES; g++) begin : g_flat
    assign desc_flat[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int PW     = 4,
  parameter int OW     = 12,
  parameter int FW     = 12,
  parameter int DW     = 16,
  parameter int NPAGES = 1 << PW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  logic [PW+OW-1:0]  va,
  input  logic [DW-1:0]     desc,
  output logic [PW-1:0]     page,
  output logic [NPAGES-1:0] pf_hit,
  output logic [NPAGES-1:0] wf_hit,
  output logic [FW+OW-1:0]  pa_o,
  output logic              cache_o,
  output logic              fault_o
);
  logic pf, wf, unused_rsv;

  assign page       = va[PW+OW-1 -: PW];
  assign pf         = valid & ~desc[EN_BIT];
  assign wf         = valid & desc[EN_BIT] & write & desc[WP_BIT];
  assign pf_hit     = pf ? (NPAGES'(1) << page) : '0;
  assign wf_hit     = wf ? (NPAGES'(1) << page) : '0;
  assign unused_rsv = desc[RSV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_o    <= '0;
      cache_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      fault_o <= pf | wf;
      if (valid) begin
        pa_o    <= {desc[FRAME_LSB +: FW], va[OW-1:0]};
        cache_o <= desc[CA_BIT] & ~(pf | wf);
      end
    end
  end
endmodule

// File: rtl/pgx_fault_log.sv
module pgx_fault_log #(
  parameter int NPAGES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPAGES-1:0] set_bits,
  input  logic              clr,
  output logic [NPAGES-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else     bits <= (clr ? '0 : bits) | set_bits;
  end
endmodule

// File: rtl/pgx_mmu.sv
module pgx_mmu
  import pgx_pkg::*;
#(
  parameter int PW  = PAGE_BITS,
  parameter int OW  = OFF_BITS,
  parameter int FW  = FRAME_BITS,
  parameter int DW  = DESC_W,
  parameter int AW  = CFG_AW,
  localparam int NPAGES = 1 << PW,
  localparam int VW     = PW + OW,
  localparam int PAW    = FW + OW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xl_valid,
  input  logic           xl_write,
  input  logic [VW-1:0]  xl_va,
  output logic [PAW-1:0] pa_o,
  output logic           cache_o,
  output logic           fault_o,
  input  logic           cfg_sel,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata
);
  localparam logic [AW-2:0] PF_IDX = (AW-1)'(NPAGES);
  localparam logic [AW-2:0] WF_IDX = (AW-1)'(NPAGES + 1);

  logic [AW-2:0]        widx;
  logic                 is_desc, is_pf, is_wf, rd_stb, unused_lsb;
  logic [PW-1:0]        page;
  logic [DW-1:0]        lk_desc, rd_desc, rd_mux;
  logic [NPAGES-1:0]    pf_hit, wf_hit, pf_bits, wf_bits;
  logic [NPAGES*DW-1:0] desc_flat;

  assign widx       = cfg_addr[AW-1:1];
  assign unused_lsb = cfg_addr[0];
  assign is_desc    = widx < PF_IDX;
  assign is_pf      = widx == PF_IDX;
  assign is_wf      = widx == WF_IDX;
  assign rd_stb     = cfg_sel & ~cfg_we;

  pgx_desc_file #(.NPAGES(NPAGES), .PW(PW), .DW(DW)) u_desc (
    .clk(clk), .rst(rst),
    .wr_en(cfg_sel & cfg_we & is_desc), .wr_idx(widx[PW-1:0]), .wr_data(cfg_wdata),
    .lk_page(page), .lk_desc(lk_desc),
    .rd_idx(widx[PW-1:0]), .rd_desc(rd_desc),
    .desc_flat(desc_flat)
  );

  pgx_xlate #(.PW(PW), .OW(OW), .FW(FW), .DW(DW), .NPAGES(NPAGES)) u_xl (
    .clk(clk), .rst(rst), .valid(xl_valid), .write(xl_write), .va(xl_va),
    .desc(lk_desc), .page(page), .pf_hit(pf_hit), .wf_hit(wf_hit),
    .pa_o(pa_o), .cache_o(cache_o), .fault_o(fault_o)
  );

  pgx_fault_log #(.NPAGES(NPAGES)) u_pf (
    .clk(clk), .rst(rst), .set_bits(pf_hit), .clr(rd_stb & is_pf), .bits(pf_bits)
  );

  pgx_fault_log #(.NPAGES(NPAGES)) u_wf (
    .clk(clk), .rst(rst), .set_bits(wf_hit), .clr(rd_stb & is_wf), .bits(wf_bits)
  );

  always_comb begin
    if (is_desc)    rd_mux = rd_desc;
    else if (is_pf) rd_mux = DW'(pf_bits);
    else if (is_wf) rd_mux = DW'(wf_bits);
    else            rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (rd_stb) cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pgx_mmu_chk.sv
module pgx_mmu_chk #(
  parameter int PW = 4,
  parameter int OW = 12,
  parameter int FW = 12,
  parameter int DW = 16,
  parameter int AW = 6,
  localparam int NPAGES = 1 << PW
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 xl_valid,
  input logic                 xl_write,
  input logic [PW+OW-1:0]     xl_va,
  input logic [FW+OW-1:0]     pa_o,
  input logic                 cache_o,
  input logic                 fault_o,
  input logic                 cfg_sel,
  input logic                 cfg_we,
  input logic [AW-1:0]        cfg_addr,
  input logic [NPAGES-1:0]    pf_bits,
  input logic [NPAGES-1:0]    wf_bits,
  input logic [NPAGES*DW-1:0] desc_flat
);
  localparam logic [AW-2:0] PF_IDX = (AW-1)'(NPAGES);

  logic [PW-1:0] pg;
  logic          cur_en, cur_wp, unused_chk;

  assign pg         = xl_va[PW+OW-1 -: PW];
  assign cur_en     = desc_flat[int'(pg)*DW + 0];
  assign cur_wp     = desc_flat[int'(pg)*DW + 1];
  assign unused_chk = cfg_addr[0];

  // R11
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $past(xl_valid));

  // R2
  pa_offset_chk: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> pa_o[OW-1:0] == $past(xl_va[OW-1:0]));

  // R6
  cache_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !cache_o);

  // R4
  page_fault_log_chk: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && !cur_en) |=> (fault_o && pf_bits[$past(pg)]));

  // R5
  write_fault_log_chk: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_write && cur_en && cur_wp) |=> (fault_o && wf_bits[$past(pg)]));

  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel && !cfg_we && cfg_addr[AW-1:1] == PF_IDX && !xl_valid) |=> pf_bits == '0);

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel && cfg_we && cfg_addr[AW-1:1] >= PF_IDX) |=> $stable(desc_flat));
endmodule

bind pgx_mmu pgx_mmu_chk #(.PW(PW), .OW(OW), .FW(FW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_write(xl_write), .xl_va(xl_va),
  .pa_o(pa_o), .cache_o(cache_o), .fault_o(fault_o),
  .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .pf_bits(pf_bits), .wf_bits(wf_bits), .desc_flat(desc_flat)
);

// File: tb/sim_pgx_mmu.sv
`timescale 1ns/1ps
module sim_pgx_mmu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xl_valid = 1'b0, xl_write = 1'b0;
  logic [15:0] xl_va = '0;
  logic [23:0] pa_o;
  logic        cache_o, fault_o;
  logic        cfg_sel = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgx_mmu u0 (
    .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_write(xl_write), .xl_va(xl_va),
    .pa_o(pa_o), .cache_o(cache_o), .fault_o(fault_o),
    .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk);
    cfg_sel = 0;
    d = cfg_rdata;
  endtask

  task automatic access(input logic [15:0] va, input bit wr,
                        output logic [23:0] pa, output logic ca, output logic ft);
    @(negedge clk);
    xl_valid = 1; xl_write = wr; xl_va = va;
    @(negedge clk);
    xl_valid = 0; xl_write = 0;
    pa = pa_o; ca = cache_o; ft = fault_o;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(pa_o == 0 && cache_o == 0 && fault_o == 0, "R1 outputs", {pa_o, 6'b0, cache_o, fault_o}, 0);
    cfg_rd(6'h0A, d); chk(d == 0, "R1 descriptor 5", d, 0);
    cfg_rd(6'h20, d); chk(d == 0, "R1 page-fault map", d, 0);
    cfg_rd(6'h22, d); chk(d == 0, "R1 write-fault map", d, 0);
  endtask

  task automatic t_translate();
    logic [23:0] pa; logic ca, ft;
    cfg_wr(6'h06, 16'hABC5);
    cfg_wr(6'h0E, 16'h0011);
    access(16'h3123, 0, pa, ca, ft);
    chk(pa == 24'hABC123, "R2 page 3 address", pa, 24'hABC123);
    chk(ca == 1 && ft == 0, "R6 cacheable page", {ca, ft}, 2'b10);
    access(16'h7FFF, 1, pa, ca, ft);
    chk(pa == 24'h001FFF, "R2 page 7 address", pa, 24'h001FFF);
    chk(ca == 0 && ft == 0, "R6 non-cacheable page", {ca, ft}, 2'b00);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    cfg_wr(6'h12, 16'h123F);
    cfg_rd(6'h12, d); chk(d == 16'h1237, "R3 reserved bit masked", d, 16'h1237);
    cfg_rd(6'h13, d); chk(d == 16'h1237, "R3 offset bit 0 ignored", d, 16'h1237);
    cfg_rd(6'h06, d); chk(d == 16'hABC5, "R3 descriptor 3", d, 16'hABC5);
  endtask

  task automatic t_pagefault();
    logic [23:0] pa; logic ca, ft; logic [15:0] d;
    access(16'h5000, 0, pa, ca, ft);
    chk(ft == 1, "R4 fault on disabled page", ft, 1);
    chk(ca == 0, "R6 no cache on fault", ca, 0);
    @(negedge clk);
    chk(fault_o == 0, "R11 pulse ends", fault_o, 0);
    cfg_rd(6'h22, d); chk(d == 0, "R4 write map untouched", d, 0);
    cfg_rd(6'h20, d); chk(d == 16'h0020, "R4 page-fault bit 5", d, 16'h0020);
    cfg_rd(6'h20, d); chk(d == 0, "R8 cleared after read", d, 0);
  endtask

  task automatic t_writefault();
    logic [23:0] pa; logic ca, ft; logic [15:0] d;
    cfg_wr(6'h04, 16'h4447);
    access(16'h2010, 0, pa, ca, ft);
    chk(ft == 0 && ca == 1, "R5 read of protected page", {ca, ft}, 2'b10);
    access(16'h2010, 1, pa, ca, ft);
    chk(ft == 1 && ca == 0, "R5 write of protected page", {ca, ft}, 2'b01);
    chk(pa == 24'h444010, "R2 faulting address", pa, 24'h444010);
    cfg_rd(6'h22, d); chk(d == 16'h0004, "R5 write-fault bit 2", d, 16'h0004);
    cfg_rd(6'h20, d); chk(d == 0, "R5 page map untouched", d, 0);
    cfg_rd(6'h22, d); chk(d == 0, "R8 write map cleared", d, 0);
  endtask

  task automatic t_sticky();
    logic [23:0] pa; logic ca, ft; logic [15:0] d;
    access(16'h5ABC, 0, pa, ca, ft);
    access(16'h6001, 1, pa, ca, ft);
    access(16'h3000, 0, pa, ca, ft);
    chk(ft == 0, "R7 good access no fault", ft, 0);
    @(negedge clk);
    chk(fault_o == 0, "R11 idle cycle", fault_o, 0);
    cfg_rd(6'h20, d); chk(d == 16'h0060, "R7 accumulated bits", d, 16'h0060);
  endtask

  task automatic t_simul();
    logic [23:0] pa; logic ca, ft; logic [15:0] d;
    access(16'h8000, 0, pa, ca, ft);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 0; cfg_addr = 6'h20;
    xl_valid = 1; xl_write = 0; xl_va = 16'hA123;
    @(negedge clk);
    cfg_sel = 0; xl_valid = 0;
    d = cfg_rdata;
    chk(d == 16'h0100, "R9 read returns old", d, 16'h0100);
    chk(fault_o == 1, "R9 new fault pulse", fault_o, 1);
    cfg_rd(6'h20, d); chk(d == 16'h0400, "R9 only new bit kept", d, 16'h0400);
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    cfg_wr(6'h20, 16'hFFFF);
    cfg_wr(6'h22, 16'hFFFF);
    cfg_wr(6'h24, 16'hFFFF);
    cfg_wr(6'h3E, 16'hFFFF);
    cfg_rd(6'h20, d); chk(d == 0, "R10 page map not writable", d, 0);
    cfg_rd(6'h22, d); chk(d == 0, "R10 write map not writable", d, 0);
    cfg_rd(6'h24, d); chk(d == 0, "R10 read above range", d, 0);
    cfg_rd(6'h3E, d); chk(d == 0, "R10 read top offset", d, 0);
    cfg_rd(6'h00, d); chk(d == 0, "R10 descriptor 0 untouched", d, 0);
    cfg_rd(6'h02, d); chk(d == 0, "R10 descriptor 1 untouched", d, 0);
    cfg_rd(6'h06, d); chk(d == 16'hABC5, "R10 descriptor 3 untouched", d, 16'hABC5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_translate();
    t_readback();
    t_pagefault();
    t_writefault();
    t_sticky();
    t_simul();
    t_ignore();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule